// File: doc/BRIEF.md
# Paravirtual Device Control Register File

This block is the control-plane register file of a memory-mapped paravirtual device. A driver reaches it over a simple 32-bit read/write bus with an address, write data, a write strobe and a read strobe. The block returns identification words and lets the driver read the device's 64-bit offered-feature set one 32-bit word at a time through a selector. The driver's accepted-feature set is written the same way through its own selector. The block also holds the page size the driver uses and a device status byte.

Two device-side event pulses mark the used-ring-updated cause and the configuration-changed cause. These causes collect in a sticky interrupt cause register. The single interrupt line is high whenever any cause is pending. The driver clears causes by writing a mask of them to a separate acknowledge register.

Writing zero to the status register performs a device reset: all driver-written state and pending causes are cleared, and a one-cycle pulse goes out to the queue logic. Addresses at 0x100 and above are passed through to a device-specific configuration window, with the byte offset into that window.

Top module: `pvdev_ctrl_regs`

## Requirements
- R1: Reads return 0x74726976 at offset 0x000, 1 at 0x004, the DEV_TYPE parameter (default 1) at 0x008 and the VENDOR parameter (default 0x0000ABCD) at 0x00C.
- R2: A read of 0x010 returns 32 bits of the offered-feature parameter. The selector last written at 0x014 picks the word: selector 0 gives bits 31:0 and selector 1 gives bits 63:32.
- R3: A selector value of 2 or more makes a read of 0x010 return zero, and makes a write to 0x020 change nothing.
- R4: A write to 0x020 loads accepted-feature word N, where N is the selector last written at 0x024. The 64-bit accepted set appears on drv_features, with word 1 in bits 63:32.
- R5: A write to 0x028 is stored as the page size only when its value is a power of two. Any other value leaves page_size unchanged.
- R6: A non-zero write to 0x070 ORs its low 8 bits into the status byte. A read of 0x070 returns that byte zero-extended.
- R7: A write of zero to 0x070 clears the status byte, the accepted features, both selectors, the page size and all interrupt causes, and this clear takes priority over any cause pulse in the same cycle. queue_rst is high for exactly the one cycle after that write.
- R8: A pulse on evt_used sets cause bit 0 and a pulse on evt_cfg sets cause bit 1. The causes stay set until cleared, read back at 0x060, and irq is high exactly when some cause is set.
- R9: Each bit set in a write to 0x064 clears the matching cause bit, unless a pulse for that cause arrives in the same cycle, in which case the bit stays set.
- R10: Read data is registered: it appears on bus_rdata the cycle after bus_rd and holds until the next read. Write-only and unmapped offsets below 0x100 read as zero.
- R11: For addresses at 0x100 and above, cfg_sel is high while a strobe is present and cfg_off gives the address minus 0x100. A read there returns cfg_rdata on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| cfg_sel | output | 1 | Access targets the device configuration window |
| cfg_off | output | 12 | Byte offset into the configuration window |
| cfg_rdata | input | 32 | Read data from the configuration window |
| evt_used | input | 1 | Used-ring-updated event pulse |
| evt_cfg | input | 1 | Configuration-changed event pulse |
| irq | output | 1 | Interrupt, high while any cause is pending |
| queue_rst | output | 1 | One-cycle reset pulse to the queue logic |
| drv_features | output | 64 | Driver-accepted feature bits |
| page_size | output | 32 | Page size in bytes |
| dev_status | output | 8 | Device status byte |

## Verification
The bench goes after the cycle in which an acknowledge and a new event for the same cause coincide. A design that lets the clear win loses an interrupt, and 0x060 reads back zero. It also sets selectors beyond the second word, where a design that wraps the index would alias word 0 or 1 on reads, or would corrupt an accepted word on writes. It writes a page size that is not a power of two, which a design without the check would store. Finally, it issues a status write of zero while causes and selectors are live. A design that misses any part of that clear, or that stretches or omits the queue reset pulse, shows a stale value at the ports or a pulse of the wrong length.

// File: rtl/pvdev_pkg.sv
`timescale 1ns/1ps
// Shared offsets and constants of the paravirtual device control register file.
// Assumes a 12-bit byte address space and 32-bit register words.
package pvdev_pkg;
    localparam int unsigned OFF_MAGIC    = 'h000;
    localparam int unsigned OFF_VERSION  = 'h004;
    localparam int unsigned OFF_DEVTYPE  = 'h008;
    localparam int unsigned OFF_VENDOR   = 'h00C;
    localparam int unsigned OFF_HFEAT    = 'h010;
    localparam int unsigned OFF_HSEL     = 'h014;
    localparam int unsigned OFF_GFEAT    = 'h020;
    localparam int unsigned OFF_GSEL     = 'h024;
    localparam int unsigned OFF_PAGE     = 'h028;
    localparam int unsigned OFF_ISR      = 'h060;
    localparam int unsigned OFF_ACK      = 'h064;
    localparam int unsigned OFF_STATUS   = 'h070;
    localparam int unsigned OFF_CFG_BASE = 'h100;

    localparam logic [31:0] MAGIC_WORD   = 32'h7472_6976;
    localparam logic [31:0] VERSION_WORD = 32'd1;

    // Interrupt cause bit positions.
    localparam int unsigned CAUSE_USED = 0;
    localparam int unsigned CAUSE_CFG  = 1;
    localparam int unsigned CAUSE_W    = 2;
endpackage

// File: rtl/pvdev_feat_win.sv
`timescale 1ns/1ps
// Feature window: holds the offered-feature and accepted-feature selectors,
// presents the selected offered word and stores accepted words.
// Assumes single-cycle write strobes; dev_clr clears both selectors and the
// accepted words, and it overrides any write in the same cycle.
module pvdev_feat_win #(
    parameter int unsigned FEAT_WORDS = 2,
    parameter logic [FEAT_WORDS*32-1:0] HOST_FEATURES = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dev_clr,
    input  logic                     hsel_we,
    input  logic                     gsel_we,
    input  logic                     gfeat_we,
    input  logic [31:0]              wdata,
    output logic [31:0]              hfeat_word,
    output logic [FEAT_WORDS*32-1:0] guest_feat
);
    localparam int unsigned IDX_W = (FEAT_WORDS > 1) ? $clog2(FEAT_WORDS) : 1;

    logic [31:0] hsel_q;
    logic [31:0] gsel_q;
    logic        h_in_range;
    logic        g_in_range;
    logic [IDX_W-1:0] h_idx;

    assign h_in_range = (hsel_q < FEAT_WORDS);
    assign g_in_range = (gsel_q < FEAT_WORDS);
    assign h_idx      = hsel_q[IDX_W-1:0];

    // Selector registers, cleared by bus reset or device reset.
    always_ff @(posedge clk) begin
        if (!rst_n || dev_clr) begin
            hsel_q <= '0;
            gsel_q <= '0;
        end else begin
            if (hsel_we) hsel_q <= wdata;
            if (gsel_we) gsel_q <= wdata;
        end
    end

    // Offered word mux: out-of-range selectors read zero.
    always_comb begin
        hfeat_word = '0;
        for (int i = 0; i < FEAT_WORDS; i++) begin
            if (h_in_range && (h_idx == IDX_W'(i)))
                hfeat_word = HOST_FEATURES[i*32 +: 32];
        end
    end

    // One accepted-feature word register per implemented word.
    for (genvar w = 0; w < FEAT_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n || dev_clr)
                guest_feat[w*32 +: 32] <= '0;
            else if (gfeat_we && g_in_range && (gsel_q[IDX_W-1:0] == IDX_W'(w)))
                guest_feat[w*32 +: 32] <= wdata;
        end
    end

    // R3: a write with an out-of-range selector leaves every accepted word alone.
    p_ignore_oor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gfeat_we && !g_in_range && !dev_clr) |=> $stable(guest_feat));

    // R7: device reset returns both selectors to zero.
    p_sel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_clr |=> (hsel_q == 0 && gsel_q == 0 && guest_feat == '0));
endmodule

// File: rtl/pvdev_dev_state.sv
`timescale 1ns/1ps
// Device state: status byte, page size, device-reset detection and the
// one-cycle queue reset pulse.
// Assumes the status write enable is decoded by the parent.
module pvdev_dev_state #(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_we,
    input  logic              page_we,
    input  logic [31:0]       wdata,
    output logic              dev_clr,
    output logic              queue_rst,
    output logic [STAT_W-1:0] status,
    output logic [31:0]       page_size
);
    logic page_ok;

    assign dev_clr = status_we && (wdata == '0);
    assign page_ok = (wdata != '0) && ((wdata & (wdata - 32'd1)) == '0);

    // Status byte: non-zero writes accumulate flags, zero clears.
    always_ff @(posedge clk) begin
        if (!rst_n || dev_clr)
            status <= '0;
        else if (status_we)
            status <= status | wdata[STAT_W-1:0];
    end

    // Page size: accepts only powers of two.
    always_ff @(posedge clk) begin
        if (!rst_n || dev_clr)
            page_size <= '0;
        else if (page_we && page_ok)
            page_size <= wdata;
    end

    // Queue reset pulse, registered one cycle after the zero write.
    always_ff @(posedge clk) begin
        if (!rst_n) queue_rst <= 1'b0;
        else        queue_rst <= dev_clr;
    end

    // R7: reset pulse follows a zero status write, with status cleared.
    p_qrst_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_clr |=> (queue_rst && status == '0 && page_size == '0));

    // R7: pulse lasts one cycle unless another zero write arrived.
    p_qrst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_rst && !dev_clr) |=> !queue_rst);

    // R5: rejected page size writes keep the old value.
    p_page_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (page_we && !page_ok && !dev_clr) |=> $stable(page_size));
endmodule

// File: rtl/pvdev_irq_ctl.sv
`timescale 1ns/1ps
// Interrupt cause register: sticky causes set by event pulses, cleared by
// acknowledge bits or device reset. A cause pulse beats its acknowledge.
// Assumes event pulses are synchronous to clk.
module pvdev_irq_ctl #(
    parameter int unsigned NCAUSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_clr,
    input  logic [NCAUSE-1:0] cause_set,
    input  logic              ack_we,
    input  logic [NCAUSE-1:0] ack_mask,
    output logic [NCAUSE-1:0] isr,
    output logic              irq
);
    // Per-cause sticky bit; set has priority over acknowledge.
    for (genvar c = 0; c < NCAUSE; c++) begin : g_cause
        always_ff @(posedge clk) begin
            if (!rst_n || dev_clr)
                isr[c] <= 1'b0;
            else if (cause_set[c])
                isr[c] <= 1'b1;
            else if (ack_we && ack_mask[c])
                isr[c] <= 1'b0;
        end

        // R9: a cause pulse in the same cycle as its acknowledge keeps the bit.
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_set[c] && !dev_clr) |=> isr[c]);

        // R9: a lone acknowledge clears the bit.
        p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we && ack_mask[c] && !cause_set[c]) |=> !isr[c]);
    end

    // Single interrupt line.
    assign irq = |isr;

    // R7: device reset empties the cause register.
    p_clr_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_clr |=> (isr == '0 && !irq));
endmodule

// File: rtl/pvdev_ctrl_regs.sv
`timescale 1ns/1ps
// Control register file of a memory-mapped paravirtual device: decodes the
// register bus, returns registered read data, and routes accesses at and
// above the configuration base to an external configuration window.
// Assumes one-cycle strobes and that bus_wr and bus_rd are never both high.
module pvdev_ctrl_regs
    import pvdev_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned FEAT_WORDS = 2,
    parameter int unsigned STAT_W     = 8,
    parameter logic [31:0] DEV_TYPE   = 32'd1,
    parameter logic [31:0] VENDOR     = 32'h0000_ABCD,
    parameter logic [FEAT_WORDS*32-1:0] HOST_FEATURES = 64'h0000_0003_8000_0021
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    output logic                     cfg_sel,
    output logic [ADDR_W-1:0]        cfg_off,
    input  logic [31:0]              cfg_rdata,
    input  logic                     evt_used,
    input  logic                     evt_cfg,
    output logic                     irq,
    output logic                     queue_rst,
    output logic [FEAT_WORDS*32-1:0] drv_features,
    output logic [31:0]              page_size,
    output logic [STAT_W-1:0]        dev_status
);
    localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(OFF_CFG_BASE);

    logic              in_cfg;
    logic              dev_clr;
    logic [31:0]       hfeat_word;
    logic [CAUSE_W-1:0] isr;
    logic [CAUSE_W-1:0] cause_set;

    // Decode helper: write strobe hitting a given fixed offset.
    function automatic logic wr_hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return (a == ADDR_W'(off));
    endfunction

    assign in_cfg  = (bus_addr >= CFG_BASE);
    assign cfg_sel = in_cfg && (bus_wr || bus_rd);
    assign cfg_off = bus_addr - CFG_BASE;

    assign cause_set[CAUSE_USED] = evt_used;
    assign cause_set[CAUSE_CFG]  = evt_cfg;

    pvdev_feat_win #(
        .FEAT_WORDS   (FEAT_WORDS),
        .HOST_FEATURES(HOST_FEATURES)
    ) u_feat (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_clr   (dev_clr),
        .hsel_we   (bus_wr && wr_hit(bus_addr, OFF_HSEL)),
        .gsel_we   (bus_wr && wr_hit(bus_addr, OFF_GSEL)),
        .gfeat_we  (bus_wr && wr_hit(bus_addr, OFF_GFEAT)),
        .wdata     (bus_wdata),
        .hfeat_word(hfeat_word),
        .guest_feat(drv_features)
    );

    pvdev_dev_state #(
        .STAT_W(STAT_W)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_we(bus_wr && wr_hit(bus_addr, OFF_STATUS)),
        .page_we  (bus_wr && wr_hit(bus_addr, OFF_PAGE)),
        .wdata    (bus_wdata),
        .dev_clr  (dev_clr),
        .queue_rst(queue_rst),
        .status   (dev_status),
        .page_size(page_size)
    );

    pvdev_irq_ctl #(
        .NCAUSE(CAUSE_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_clr  (dev_clr),
        .cause_set(cause_set),
        .ack_we   (bus_wr && wr_hit(bus_addr, OFF_ACK)),
        .ack_mask (bus_wdata[CAUSE_W-1:0]),
        .isr      (isr),
        .irq      (irq)
    );

    // Registered read mux; holds the last value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (in_cfg) begin
                bus_rdata <= cfg_rdata;
            end else begin
                unique case (bus_addr)
                    ADDR_W'(OFF_MAGIC):   bus_rdata <= MAGIC_WORD;
                    ADDR_W'(OFF_VERSION): bus_rdata <= VERSION_WORD;
                    ADDR_W'(OFF_DEVTYPE): bus_rdata <= DEV_TYPE;
                    ADDR_W'(OFF_VENDOR):  bus_rdata <= VENDOR;
                    ADDR_W'(OFF_HFEAT):   bus_rdata <= hfeat_word;
                    ADDR_W'(OFF_ISR):     bus_rdata <= 32'(isr);
                    ADDR_W'(OFF_STATUS):  bus_rdata <= 32'(dev_status);
                    default:              bus_rdata <= '0;
                endcase
            end
        end
    end

    // R10: read data holds while no read is issued.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11: configuration window reads return the window data next cycle.
    p_cfg_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_cfg) |=> (bus_rdata == $past(cfg_rdata)));

    // R8: interrupt line agrees with the cause register read path.
    p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_ISR) && irq) |=> (bus_rdata != '0));
endmodule

// File: tb/pvdev_ctrl_regs_tb.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed corner cases.
module pvdev_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cfg_sel;
    logic [11:0] cfg_off;
    logic [31:0] cfg_rdata = '0;
    logic        evt_used = 1'b0;
    logic        evt_cfg = 1'b0;
    logic        irq;
    logic        queue_rst;
    logic [63:0] drv_features;
    logic [31:0] page_size;
    logic [7:0]  dev_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pvdev_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_sel(cfg_sel), .cfg_off(cfg_off), .cfg_rdata(cfg_rdata),
        .evt_used(evt_used), .evt_cfg(evt_cfg), .irq(irq), .queue_rst(queue_rst),
        .drv_features(drv_features), .page_size(page_size), .dev_status(dev_status)
    );

    // Vector: {is_write, addr, wdata, expected read data}
    localparam int NV = 22;
    localparam logic [76:0] VEC [0:NV-1] = '{
        {1'b0, 12'h000, 32'h0, 32'h7472_6976},   // R1 magic
        {1'b0, 12'h004, 32'h0, 32'h0000_0001},   // R1 version
        {1'b0, 12'h008, 32'h0, 32'h0000_0001},   // R1 device type
        {1'b0, 12'h00C, 32'h0, 32'h0000_ABCD},   // R1 vendor
        {1'b0, 12'h010, 32'h0, 32'h8000_0021},   // R2 word 0
        {1'b1, 12'h014, 32'h1, 32'h0},
        {1'b0, 12'h010, 32'h0, 32'h0000_0003},   // R2 word 1
        {1'b1, 12'h014, 32'h2, 32'h0},
        {1'b0, 12'h010, 32'h0, 32'h0000_0000},   // R3 out of range
        {1'b1, 12'h014, 32'h1_0000, 32'h0},
        {1'b0, 12'h010, 32'h0, 32'h0000_0000},   // R3 large selector
        {1'b1, 12'h024, 32'h0, 32'h0},
        {1'b1, 12'h020, 32'hDEAD_BEEF, 32'h0},   // R4 word 0
        {1'b1, 12'h024, 32'h1, 32'h0},
        {1'b1, 12'h020, 32'h0000_0055, 32'h0},   // R4 word 1
        {1'b1, 12'h024, 32'h5, 32'h0},
        {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0},   // R3 ignored write
        {1'b1, 12'h028, 32'h0000_1000, 32'h0},   // R5 accepted
        {1'b1, 12'h028, 32'h0000_0300, 32'h0},   // R5 rejected
        {1'b1, 12'h070, 32'h1, 32'h0},           // R6
        {1'b1, 12'h070, 32'h4, 32'h0},           // R6
        {1'b0, 12'h070, 32'h0, 32'h0000_0005}    // R6 accumulated flags
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R8 irq after reset", {63'b0, irq}, 64'd0);
        check("R7 queue_rst after reset", {63'b0, queue_rst}, 64'd0);
        check("R4 features after reset", drv_features, 64'd0);
        check("R5 page after reset", {32'b0, page_size}, 64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) begin
                bus_write(VEC[i][75:64], VEC[i][63:32]);
            end else begin
                bus_read(VEC[i][75:64], rd);
                check($sformatf("R1/R2/R3/R6 vector %0d", i), {32'b0, rd}, {32'b0, VEC[i][31:0]});
            end
        end
        check("R4 accepted features", drv_features, 64'h0000_0055_DEAD_BEEF);
        check("R5 page size", {32'b0, page_size}, 64'h1000);
        check("R6 status port", {56'b0, dev_status}, 64'h5);

        // R10: write-only offset reads zero; data holds afterwards
        bus_read(12'h014, rd);
        check("R10 write-only reads zero", {32'b0, rd}, 64'd0);
        bus_read(12'h000, rd);
        repeat (2) @(negedge clk);
        check("R10 rdata hold", {32'b0, bus_rdata}, 64'h7472_6976);

        // R11: configuration window
        cfg_rdata = 32'h5A5A_1234;
        @(negedge clk);
        bus_addr = 12'h107; bus_rd = 1'b1;
        #1;
        check("R11 cfg_sel", {63'b0, cfg_sel}, 64'd1);
        check("R11 cfg_off", {52'b0, cfg_off}, 64'h7);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R11 cfg read data", {32'b0, bus_rdata}, 64'h5A5A_1234);
        #1;
        check("R11 cfg_sel idle", {63'b0, cfg_sel}, 64'd0);

        // R8: events set sticky causes
        @(negedge clk); evt_used = 1'b1;
        @(negedge clk); evt_used = 1'b0;
        check("R8 irq after used event", {63'b0, irq}, 64'd1);
        @(negedge clk); evt_cfg = 1'b1;
        @(negedge clk); evt_cfg = 1'b0;
        bus_read(12'h060, rd);
        check("R8 both causes", {32'b0, rd}, 64'h3);

        // R9: ack cfg only
        bus_write(12'h064, 32'h2);
        bus_read(12'h060, rd);
        check("R9 partial ack", {32'b0, rd}, 64'h1);

        // R9: collision, set wins
        @(negedge clk);
        bus_addr = 12'h064; bus_wdata = 32'h1; bus_wr = 1'b1; evt_used = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_used = 1'b0;
        bus_read(12'h060, rd);
        check("R9 set beats ack", {32'b0, rd}, 64'h1);
        bus_write(12'h064, 32'h1);
        bus_read(12'h060, rd);
        check("R9 ack clears", {32'b0, rd}, 64'h0);
        check("R8 irq low after ack", {63'b0, irq}, 64'd0);

        // R7: device reset with live state
        bus_write(12'h014, 32'h1);
        @(negedge clk); evt_cfg = 1'b1;
        @(negedge clk); evt_cfg = 1'b0;
        @(negedge clk);
        bus_addr = 12'h070; bus_wdata = 32'h0; bus_wr = 1'b1; evt_used = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_used = 1'b0;
        check("R7 queue_rst pulse", {63'b0, queue_rst}, 64'd1);
        @(negedge clk);
        check("R7 queue_rst one cycle", {63'b0, queue_rst}, 64'd0);
        check("R7 features cleared", drv_features, 64'd0);
        check("R7 page cleared", {32'b0, page_size}, 64'd0);
        check("R7 irq cleared", {63'b0, irq}, 64'd0);
        bus_read(12'h070, rd);
        check("R7 status cleared", {32'b0, rd}, 64'd0);
        bus_read(12'h060, rd);
        check("R7 causes cleared", {32'b0, rd}, 64'd0);
        bus_read(12'h010, rd);
        check("R7 selector cleared", {32'b0, rd}, 64'h8000_0021);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule